// File: doc/BRIEF.md
# Page read buffer with hit detection

This block sits between an asynchronous read port and a flash-style memory array. Reads are grouped into pages of four 32-bit words, and the two lowest word-address bits pick the word inside a page. The block remembers one page. The first read to a page waits the long array latency and fetches all four words in one wide transfer. Later reads that stay inside the remembered page are served from local registers after a much shorter latency.

The requester pulses `rd_req_i` with a word address. The address is captured on that edge, so the address bus may change immediately afterwards. After the applicable latency, `rd_valid_o` pulses for one cycle together with the word and a hit flag. When latch-controlled reads are selected, page mode is disabled and every read takes the long path. A write or a power-down event discards the remembered page. Both latencies are parameters counted in clock cycles, and the long one must exceed the short one.

Top module: `pb_page_buffer`

## Requirements
- R1: After reset `rd_valid_o`, `busy_o` and `arr_rd_o` are low and no page is held, so the first read takes the long latency.
- R2: A read outside the held page raises `rd_valid_o` exactly LONG_LAT cycles after its request edge. `rd_data_o` then carries word `addr[1:0]` of the array page `addr[ADDR_W-1:2]`, where word i occupies bits `[32*i+31:32*i]` of `arr_rdata_i`, and the page becomes the held page.
- R3: A read whose upper bits `addr[ADDR_W-1:2]` match a valid held page raises `rd_valid_o` exactly SHORT_LAT cycles after its request edge. The word comes from the stored copy, not from the current array output.
- R4: A read to a different page replaces the held page, so a later read to the old page is long again.
- R5: While `latch_mode_i` is high at the request edge, the read is long and reports no hit. The held page is neither used nor replaced.
- R6: A one-cycle pulse on `wr_evt_i` or `pdown_i` while idle discards the held page, so the next read is long.
- R7: An invalidation pulse in the same cycle as a request makes that request a long miss. The page it fetches becomes the held page.
- R8: An invalidation pulse while a long fetch is running lets that read finish with the fetched data, but the fetched page is not held afterwards.
- R9: A request made while `busy_o` is high is ignored. It produces no strobe and does not change the data or the held page.
- R10: `rd_valid_o` lasts one cycle. `rd_hit_o` is high only together with `rd_valid_o`, and only for a short-latency read.
- R11: `arr_rd_o` is high for every cycle of a long fetch and low during a short read. During the fetch `arr_page_o` holds the requested page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Read request pulse |
| rd_addr_i | input | ADDR_W | Word address, captured on the request edge |
| latch_mode_i | input | 1 | Latch-controlled read selected; disables page mode |
| wr_evt_i | input | 1 | Write to the device; invalidates the held page |
| pdown_i | input | 1 | Power-down event; invalidates the held page |
| busy_o | output | 1 | A read is in progress |
| rd_valid_o | output | 1 | One-cycle data strobe |
| rd_data_o | output | 32 | Read word |
| rd_hit_o | output | 1 | The strobed read was served from the held page |
| arr_rd_o | output | 1 | Array fetch in progress |
| arr_page_o | output | ADDR_W-2 | Page number presented to the array |
| arr_rdata_i | input | 128 | Whole page from the array, word i at bits 32*i upward |

## Verification
An invalidation can arrive in the same cycle as a lookup or a fill, and it must win in both cases. The bench drives `wr_evt_i` together with `rd_req_i`, which must give a long read whose fetched page is still held afterwards. It also pulses it in the middle of a fetch, which must let that read return fresh data while the next read to the same page is long again. A request that arrives while a fetch is still running is also applied. It is judged by counting strobes in a window after the read and by checking that the held page is unchanged.

// File: rtl/pb_pkg.sv
package pb_pkg;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_FETCH = 2'd1,
    RD_BUF   = 2'd2
  } rd_state_e;

  function automatic int unsigned lat_pick(input logic hit, input int unsigned long_lat,
                                           input int unsigned short_lat);
    return hit ? short_lat : long_lat;
  endfunction

endpackage

// File: rtl/pb_lat_timer.sv
module pb_lat_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             busy_o,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign busy_o = run_q;
  assign done_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i && !run_q) begin
      run_q <= 1'b1;
      cnt_q <= load_i - CNT_W'(1);
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/pb_page_tracker.sv
module pb_page_tracker #(
  parameter int unsigned TAG_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inval_i,
  input  logic             look_en_i,
  input  logic [TAG_W-1:0] look_tag_i,
  input  logic             fetch_i,
  input  logic             fill_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  output logic             hit_o
);

  logic [TAG_W-1:0] tag_q;
  logic             vld_q;
  logic             spoil_q;

  // an invalidation in the lookup cycle forces a miss
  assign hit_o = look_en_i && vld_q && !inval_i && (tag_q == look_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spoil_q <= 1'b0;
    end else if (fetch_i) begin
      spoil_q <= 1'b0;
    end else if (inval_i) begin
      spoil_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      tag_q <= '0;
    end else if (inval_i) begin
      vld_q <= 1'b0;
    end else if (fill_i && !spoil_q) begin
      vld_q <= 1'b1;
      tag_q <= fill_tag_i;
    end
  end

endmodule

// File: rtl/pb_page_store.sv
module pb_page_store #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [WORDS*WORD_W-1:0] page_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic [WORD_W-1:0]       word_o
);

  logic [WORD_W-1:0] word_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     word_q[g] <= '0;
      else if (load_i) word_q[g] <= page_i[g*WORD_W +: WORD_W];
    end
  end

  assign word_o = word_q[idx_i];

endmodule

// File: rtl/pb_page_buffer.sv
module pb_page_buffer
  import pb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned PAGE_WORDS = 4,
  parameter int unsigned LONG_LAT   = 8,
  parameter int unsigned SHORT_LAT  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rd_req_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  input  logic                         latch_mode_i,
  input  logic                         wr_evt_i,
  input  logic                         pdown_i,
  output logic                         busy_o,
  output logic                         rd_valid_o,
  output logic [WORD_W-1:0]            rd_data_o,
  output logic                         rd_hit_o,
  output logic                         arr_rd_o,
  output logic [ADDR_W-3:0]            arr_page_o,
  input  logic [PAGE_WORDS*WORD_W-1:0] arr_rdata_i
);

  localparam int unsigned IDX_W = $clog2(PAGE_WORDS);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;
  localparam int unsigned CNT_W = $clog2(LONG_LAT + 1);

  logic              accept, inval, hit, done, t_busy, fill;
  logic [TAG_W-1:0]  req_tag_q;
  logic [IDX_W-1:0]  req_idx_q;
  logic              req_latch_q;
  rd_state_e         state_q;
  logic [CNT_W-1:0]  lat_ld;
  logic [WORD_W-1:0] buf_word, arr_word;
  logic              valid_q, hit_q;
  logic [WORD_W-1:0] data_q;

  assign inval  = wr_evt_i || pdown_i;
  assign accept = rd_req_i && !t_busy;
  assign lat_ld = CNT_W'(lat_pick(hit, LONG_LAT, SHORT_LAT));
  assign fill   = done && (state_q == RD_FETCH) && !req_latch_q;

  pb_page_tracker #(.TAG_W(TAG_W)) u_tracker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inval_i    (inval),
    .look_en_i  (accept && !latch_mode_i),
    .look_tag_i (rd_addr_i[ADDR_W-1:IDX_W]),
    .fetch_i    (accept),
    .fill_i     (fill),
    .fill_tag_i (req_tag_q),
    .hit_o      (hit)
  );

  pb_lat_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .load_i  (lat_ld),
    .busy_o  (t_busy),
    .done_o  (done)
  );

  pb_page_store #(.WORD_W(WORD_W), .WORDS(PAGE_WORDS), .IDX_W(IDX_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (fill),
    .page_i (arr_rdata_i),
    .idx_i  (req_idx_q),
    .word_o (buf_word)
  );

  assign arr_word = arr_rdata_i[req_idx_q*WORD_W +: WORD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= RD_IDLE;
      req_tag_q   <= '0;
      req_idx_q   <= '0;
      req_latch_q <= 1'b0;
    end else if (accept) begin
      state_q     <= hit ? RD_BUF : RD_FETCH;
      req_tag_q   <= rd_addr_i[ADDR_W-1:IDX_W];
      req_idx_q   <= rd_addr_i[IDX_W-1:0];
      req_latch_q <= latch_mode_i;
    end else if (done) begin
      state_q <= RD_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= done;
      hit_q   <= done && (state_q == RD_BUF);
      if (done) data_q <= (state_q == RD_BUF) ? buf_word : arr_word;
    end
  end

  assign busy_o     = t_busy;
  assign rd_valid_o = valid_q;
  assign rd_hit_o   = hit_q;
  assign rd_data_o  = data_q;
  assign arr_rd_o   = t_busy && (state_q == RD_FETCH);
  assign arr_page_o = req_tag_q;

endmodule

// File: rtl/pb_page_buffer_chk.sv
module pb_page_buffer_chk #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned LONG_LAT  = 8,
  parameter int unsigned SHORT_LAT = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_i,
  input logic              latch_mode_i,
  input logic              wr_evt_i,
  input logic              pdown_i,
  input logic              busy_o,
  input logic              rd_valid_o,
  input logic              rd_hit_o,
  input logic              arr_rd_o,
  input logic [ADDR_W-3:0] arr_page_o
);

  logic [15:0] span_q;
  logic        lm_q, inv_q, started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      span_q    <= '0;
      lm_q      <= 1'b0;
      inv_q     <= 1'b0;
      started_q <= 1'b0;
    end else if (rd_req_i && !busy_o) begin
      span_q    <= 16'd1;
      lm_q      <= latch_mode_i;
      inv_q     <= wr_evt_i || pdown_i;
      started_q <= 1'b1;
    end else if (busy_o) begin
      span_q <= span_q + 16'd1;
    end
  end

  assert_latency_long_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_hit_o) |-> (started_q && span_q == 16'(LONG_LAT + 1)));

  assert_latency_short_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit_o |-> (span_q == 16'(SHORT_LAT + 1)));

  assert_latch_no_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && lm_q) |-> !rd_hit_o);

  assert_same_cycle_inval_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && inv_q) |-> !rd_hit_o);

  assert_busy_from_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(rd_req_i));

  assert_strobe_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  assert_hit_qualified_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit_o |-> rd_valid_o);

  assert_fetch_in_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_rd_o |-> busy_o);

  assert_page_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_rd_o && $past(arr_rd_o)) |-> $stable(arr_page_o));

endmodule

bind pb_page_buffer pb_page_buffer_chk #(
  .ADDR_W(ADDR_W), .LONG_LAT(LONG_LAT), .SHORT_LAT(SHORT_LAT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_req_i     (rd_req_i),
  .latch_mode_i (latch_mode_i),
  .wr_evt_i     (wr_evt_i),
  .pdown_i      (pdown_i),
  .busy_o       (busy_o),
  .rd_valid_o   (rd_valid_o),
  .rd_hit_o     (rd_hit_o),
  .arr_rd_o     (arr_rd_o),
  .arr_page_o   (arr_page_o)
);

// File: tb/tb_pb_page_buffer.sv
`timescale 1ns/1ps
module tb_pb_page_buffer;

  localparam int unsigned ADDR_W = 20;
  localparam int unsigned LONG   = 8;
  localparam int unsigned SHORT  = 2;

  typedef struct packed {
    logic [19:0] addr;
    logic        lm;
    logic [1:0]  inv;   // 0 none, 1 write, 2 power-down, applied while idle before the read
    logic        hit;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{20'h00010, 1'b0, 2'd0, 1'b0},
    '{20'h00013, 1'b0, 2'd0, 1'b1},
    '{20'h00011, 1'b0, 2'd0, 1'b1},
    '{20'h00020, 1'b0, 2'd0, 1'b0},
    '{20'h00022, 1'b0, 2'd0, 1'b1},
    '{20'h00021, 1'b1, 2'd0, 1'b0},
    '{20'h00023, 1'b0, 2'd0, 1'b1},
    '{20'h00020, 1'b0, 2'd1, 1'b0},
    '{20'h00021, 1'b0, 2'd0, 1'b1},
    '{20'h00031, 1'b0, 2'd2, 1'b0},
    '{20'h00032, 1'b0, 2'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req = 1'b0, lm = 1'b0, wr_evt = 1'b0, pdown = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic busy, rd_valid, rd_hit, arr_rd;
  logic [31:0] rd_data;
  logic [ADDR_W-3:0] arr_page;
  logic [127:0] arr_rdata;

  int gen = 1;
  int buf_gen = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mkword(input int g, input logic [ADDR_W-3:0] pg, input int i);
    return (32'(g) << 24) ^ (32'(pg) << 4) ^ 32'(i);
  endfunction

  always_comb
    for (int i = 0; i < 4; i++) arr_rdata[i*32 +: 32] = mkword(gen, arr_page, i);

  pb_page_buffer #(.ADDR_W(ADDR_W), .LONG_LAT(LONG), .SHORT_LAT(SHORT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .latch_mode_i(lm), .wr_evt_i(wr_evt), .pdown_i(pdown), .busy_o(busy),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_hit_o(rd_hit),
    .arr_rd_o(arr_rd), .arr_page_o(arr_page), .arr_rdata_i(arr_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_inv(input logic [1:0] kind);
    @(negedge clk);
    wr_evt = (kind == 2'd1);
    pdown  = (kind == 2'd2);
    @(negedge clk);
    wr_evt = 1'b0;
    pdown  = 1'b0;
  endtask

  // returns latency (request edge to strobe), strobe fields, and array signals one cycle in
  task automatic do_read(input logic [ADDR_W-1:0] a, input bit lmode, input bit inv_with,
                         input int mid_inv, input int extra_req,
                         output int lat, output bit hit, output logic [31:0] dat,
                         output bit arr1, output logic [ADDR_W-3:0] pg1);
    int n = 0;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a; lm = lmode; wr_evt = inv_with;
    while (1) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        rd_req = 1'b0; wr_evt = 1'b0; lm = 1'b0;
        rd_addr = ~a;
        arr1 = arr_rd; pg1 = arr_page;
      end
      if (n == mid_inv) wr_evt = 1'b1;
      if (n == mid_inv + 1 && mid_inv != 0) wr_evt = 1'b0;
      if (n == extra_req) begin rd_req = 1'b1; rd_addr = a ^ 20'h00100; end
      if (n == extra_req + 1 && extra_req != 0) rd_req = 1'b0;
      if (rd_valid || n > 100) break;
    end
    lat = n - 1; hit = rd_hit; dat = rd_data;
    wr_evt = 1'b0; rd_req = 1'b0;
    @(negedge clk);
    chk(!rd_valid, "R10 strobe one cycle", 32'(rd_valid), 32'd0);
  endtask

  task automatic read_expect(input logic [ADDR_W-1:0] a, input bit lmode, input bit inv_with,
                             input int mid_inv, input bit exp_hit, input bit refill,
                             input string req);
    int lat; bit hit; logic [31:0] dat, exp; bit arr1; logic [ADDR_W-3:0] pg1;
    gen++;
    do_read(a, lmode, inv_with, mid_inv, 0, lat, hit, dat, arr1, pg1);
    exp = exp_hit ? mkword(buf_gen, a[ADDR_W-1:2], int'(a[1:0]))
                  : mkword(gen, a[ADDR_W-1:2], int'(a[1:0]));
    chk(lat == (exp_hit ? SHORT : LONG), {req, " latency"}, 32'(lat), exp_hit ? SHORT : LONG);
    chk(hit == exp_hit, {req, " hit flag"}, 32'(hit), 32'(exp_hit));
    chk(dat == exp, {req, " data"}, dat, exp);
    chk(arr1 == !exp_hit, "R11 array fetch flag", 32'(arr1), 32'(!exp_hit));
    if (!exp_hit) chk(pg1 == a[ADDR_W-1:2], "R11 array page", 32'(pg1), 32'(a[ADDR_W-1:2]));
    if (!exp_hit && refill) buf_gen = gen;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lat; bit hit; logic [31:0] dat; bit arr1; logic [ADDR_W-3:0] pg1; int seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rd_valid, "R1 valid in reset", 32'(rd_valid), 0);
    chk(!busy, "R1 busy in reset", 32'(busy), 0);
    chk(!arr_rd, "R1 fetch in reset", 32'(arr_rd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_valid && !busy && !arr_rd, "R1 idle after reset", {29'd0, rd_valid, busy, arr_rd}, 0);

    // table: R1 first read long, R2 miss, R3 hits, R4 new page, R5 latch mode, R6 invalidation
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].inv != 2'd0) pulse_inv(VECS[i].inv);
      read_expect(VECS[i].addr, VECS[i].lm, 1'b0, 0, VECS[i].hit, !VECS[i].lm,
                  VECS[i].hit ? "R3" : (VECS[i].lm ? "R5" : (VECS[i].inv != 0 ? "R6" : "R2")));
    end
    // R4 old page 0x4 was replaced
    read_expect(20'h00012, 1'b0, 1'b0, 0, 1'b0, 1'b1, "R4 replaced page");

    // R7 invalidation in the request cycle
    read_expect(20'h00033, 1'b0, 1'b1, 0, 1'b0, 1'b1, "R7 same-cycle invalidate");
    read_expect(20'h00030, 1'b0, 1'b0, 0, 1'b1, 1'b1, "R7 fill held");

    // R8 invalidation during a fetch
    read_expect(20'h00040, 1'b0, 1'b0, 3, 1'b0, 1'b0, "R8 spoiled fetch");
    read_expect(20'h00041, 1'b0, 1'b0, 0, 1'b0, 1'b1, "R8 not held");
    read_expect(20'h00042, 1'b0, 1'b0, 0, 1'b1, 1'b1, "R8 refill held");

    // R9 request while busy
    gen++;
    do_read(20'h00052, 1'b0, 1'b0, 0, 2, lat, hit, dat, arr1, pg1);
    chk(lat == LONG, "R9 first read latency", 32'(lat), LONG);
    chk(dat == mkword(gen, 18'h00014, 2), "R9 first read data", dat, mkword(gen, 18'h00014, 2));
    buf_gen = gen;
    seen = 0;
    for (int k = 0; k < int'(LONG) + 4; k++) begin
      @(negedge clk);
      if (rd_valid) seen++;
    end
    chk(seen == 0, "R9 no extra strobe", 32'(seen), 0);
    chk(!busy, "R9 idle afterwards", 32'(busy), 0);
    read_expect(20'h00050, 1'b0, 1'b0, 0, 1'b1, 1'b1, "R9 held page kept");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule